// File: doc/BRIEF.md
# Quadword Tagged Memory

This block is a small on-chip memory built from aligned 16-byte quadwords. Each quadword has a hidden validity flag that marks its contents as a legitimate pointer. Software cannot reach the flag through ordinary data accesses. A full quadword store writes the flag from a tag input. Any narrower store into the quadword withdraws it. The memory is byte addressed and accepts stores and loads of 1, 2, 4, 8 or 16 bytes.

A quadword load returns the 128 data bits and the flag in the same response. A pointer-style load also returns the data, but only when the flag is set; when the flag is clear it returns all zeros, so a forged or damaged pointer reads as null. The flag may be held at finer granularity than a quadword (parameter `SUB_TAGS`). Only the AND of all sub-flags in a quadword is ever reported.

The tag rules apply only while the tags-active input is high. With that input low, the memory behaves as plain storage. A quadword access whose address is not 16-byte aligned is refused and reported with an error pulse.

Top module: `qword_tag_mem`

## Requirements
- R1: With `tagsActive` high, an aligned store whose `reqSize` is 4 (quadword; the codes 5 to 7 behave as 4) writes all 16 bytes. It also sets the quadword's reported tag to the value of `reqTagIn`.
- R2: `reqSize` 0, 1, 2 or 3 stores 1, 2, 4 or 8 bytes. The bytes go at the offset `reqAddr[3:0]` rounded down to a multiple of the size, and byte k of the quadword is taken from `reqWdata[8k+7:8k]`. With `tagsActive` high, such a store clears the quadword's reported tag.
- R3: An accepted load is answered on the cycle after acceptance. `rspValid` is high for one cycle, and `rspData` carries the whole addressed quadword. `rspTag` is the stored tag only for an active-mode quadword load; it is 0 for narrower loads and whenever `rspValid` is low.
- R4: A load with `reqPtr` high and quadword size in active mode returns the data when the tag is set. It returns 128 zero bits when the tag is clear.
- R5: The reported tag is the AND of all `SUB_TAGS` sub-tags of the quadword. A narrow store that touches any one of them makes the reported tag 0. A later quadword store with tag 1 makes it 1 again.
- R6: With `tagsActive` low, stores still write data but leave every tag unchanged. Loads report tag 0, and pointer-style loads return the data unmasked.
- R7: A quadword access with a nonzero `reqAddr[3:0]` raises `alignErr` for one cycle on the cycle after acceptance. It writes nothing and produces no response.
- R8: During reset `reqReady`, `rspValid` and `alignErr` are 0. Reset clears every tag, so a quadword load after reset reports tag 0. `reqReady` is 1 from the first clock edge after reset is released.
- R9: A store produces no response: `rspValid` stays low on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tagsActive | input | 1 | Enables tag handling |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqWrite | input | 1 | 1 store, 0 load |
| reqSize | input | 3 | 0 byte, 1 halfword, 2 word, 3 doubleword, 4 and above quadword |
| reqPtr | input | 1 | Pointer-style load (zero data when untagged) |
| reqAddr | input | ADDR_W (8) | Byte address; the upper bits select the quadword |
| reqWdata | input | 128 | Store data, lane positioned |
| reqTagIn | input | 1 | Tag value for quadword stores |
| rspValid | output | 1 | Load response valid |
| rspData | output | 128 | Load data |
| rspTag | output | 1 | Tag of the loaded quadword |
| alignErr | output | 1 | Misaligned quadword access pulse |

## Verification
The assertions check on every cycle that a misaligned quadword request never reaches the storage and is followed by an error pulse. They also check that a narrow store enables exactly its size in bytes, that a quadword store leaves the tag equal to the tag input, and that any partial store leaves the tag clear. Further cycle-level checks are that the tags do not move without a tag strobe, that an untagged pointer load returns zero, and that `rspTag` is never high without `rspValid`. Only the bench's scenarios can show the data results: how narrow stores merge into a quadword, where offsets are rounded down, that inactive-mode stores write data and leave tags untouched, how tag visibility is restored, and how tags behave across a reset in mid-run.

// File: rtl/qtm_pkg.sv
package qtm_pkg;
  localparam int QW_BYTES = 16;

  localparam logic [2:0] SZ_BYTE  = 3'd0;
  localparam logic [2:0] SZ_HALF  = 3'd1;
  localparam logic [2:0] SZ_WORD  = 3'd2;
  localparam logic [2:0] SZ_DWORD = 3'd3;
  localparam logic [2:0] SZ_QUAD  = 3'd4;

  // Strobes from control to datapath for one accepted request.
  typedef struct packed {
    logic                wrEn;     // write selected bytes
    logic [QW_BYTES-1:0] byteEn;   // byte lanes of the quadword
    logic                tagLoad;  // quadword store in active mode
    logic                tagClear; // partial store in active mode
    logic                tagVal;   // value for tagLoad
    logic                rdEn;     // load
    logic                ptrZero;  // zero data if untagged
    logic                tagShow;  // tag visible in response
  } qtmStrobe_t;
endpackage

// File: rtl/qtm_ctrl.sv
module qtm_ctrl
  import qtm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tagsActive,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [2:0] reqSize,
  input  logic       reqPtr,
  input  logic [3:0] reqOffset,
  input  logic       reqTagIn,
  output logic       reqReady,
  output qtmStrobe_t strb,
  output logic       alignErr
);
  logic readyQ;
  logic fire;
  logic isQuad;
  logic misalign;
  logic [QW_BYTES-1:0] laneMask;
  logic [3:0] baseOff;

  assign reqReady = readyQ;
  assign fire     = reqValid && readyQ;
  assign isQuad   = (reqSize >= SZ_QUAD);
  assign misalign = isQuad && (reqOffset != 4'd0);

  always_comb begin
    case (reqSize)
      SZ_BYTE:  begin laneMask = 16'h0001; baseOff = reqOffset; end
      SZ_HALF:  begin laneMask = 16'h0003; baseOff = {reqOffset[3:1], 1'b0}; end
      SZ_WORD:  begin laneMask = 16'h000F; baseOff = {reqOffset[3:2], 2'b00}; end
      SZ_DWORD: begin laneMask = 16'h00FF; baseOff = {reqOffset[3], 3'b000}; end
      default:  begin laneMask = 16'hFFFF; baseOff = 4'd0; end
    endcase
  end

  always_comb begin
    strb.wrEn     = fire && reqWrite && !misalign;
    strb.byteEn   = laneMask << baseOff;
    strb.tagLoad  = isQuad && tagsActive;
    strb.tagClear = !isQuad && tagsActive;
    strb.tagVal   = reqTagIn;
    strb.rdEn     = fire && !reqWrite && !misalign;
    strb.ptrZero  = reqPtr && isQuad && tagsActive;
    strb.tagShow  = isQuad && tagsActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ   <= 1'b0;
      alignErr <= 1'b0;
    end else begin
      readyQ   <= 1'b1;
      alignErr <= fire && misalign;
    end
  end

  // R7
  misalign_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqSize >= SZ_QUAD && reqOffset != 4'd0)
      |-> (!strb.wrEn && !strb.rdEn));

  // R7
  misalign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqSize >= SZ_QUAD && reqOffset != 4'd0) |=> alignErr);

  // R2
  narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && reqSize < SZ_QUAD) |-> ($countones(strb.byteEn) == (32'd1 << reqSize)));
endmodule

// File: rtl/qtm_datapath.sv
module qtm_datapath
  import qtm_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SUB_TAGS = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int SPAN    = QW_BYTES / SUB_TAGS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  qtmStrobe_t            strb,
  input  logic [IDX_W-1:0]      idx,
  input  logic [8*QW_BYTES-1:0] wdata,
  output logic                  rspValid,
  output logic [8*QW_BYTES-1:0] rspData,
  output logic                  rspTag
);
  logic [7:0] mem [DEPTH][QW_BYTES];
  logic [DEPTH-1:0][SUB_TAGS-1:0] tagQ;
  logic [DEPTH-1:0] tagAll;
  logic [SUB_TAGS-1:0] touched;
  logic [8*QW_BYTES-1:0] rdWord;

  // Sub-tags touched by the enabled byte lanes.
  for (genvar j = 0; j < SUB_TAGS; j++) begin : g_touch
    assign touched[j] = |strb.byteEn[j*SPAN +: SPAN];
  end

  // Reported tag is the AND of the sub-tags.
  for (genvar i = 0; i < DEPTH; i++) begin : g_and
    assign tagAll[i] = &tagQ[i];
  end

  always_comb begin
    for (int b = 0; b < QW_BYTES; b++) rdWord[8*b +: 8] = mem[idx][b];
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < QW_BYTES; b++) begin
      if (strb.wrEn && strb.byteEn[b]) mem[idx][b] <= wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ <= '0;
    end else if (strb.wrEn) begin
      if (strb.tagLoad)       tagQ[idx] <= {SUB_TAGS{strb.tagVal}};
      else if (strb.tagClear) tagQ[idx] <= tagQ[idx] & ~touched;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTag   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rdEn;
      rspTag   <= strb.rdEn && strb.tagShow && tagAll[idx];
      if (strb.rdEn) rspData <= (strb.ptrZero && !tagAll[idx]) ? '0 : rdWord;
    end
  end

  // R1
  quad_tag_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.tagLoad) |=> (tagAll[$past(idx)] == $past(strb.tagVal)));

  // R5
  partial_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.tagClear) |=> !tagAll[$past(idx)]);

  // R6
  tags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(strb.wrEn && (strb.tagLoad || strb.tagClear))) |=> $stable(tagQ));

  // R4
  ptr_null_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.ptrZero && !tagAll[idx]) |=> (rspValid && rspData == '0));

  // R3
  tag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspTag);
endmodule

// File: rtl/qword_tag_mem.sv
module qword_tag_mem
  import qtm_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SUB_TAGS = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ADDR_W  = IDX_W + 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tagsActive,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [2:0]            reqSize,
  input  logic                  reqPtr,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [8*QW_BYTES-1:0] reqWdata,
  input  logic                  reqTagIn,
  output logic                  rspValid,
  output logic [8*QW_BYTES-1:0] rspData,
  output logic                  rspTag,
  output logic                  alignErr
);
  qtmStrobe_t strb;

  qtm_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tagsActive (tagsActive),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqPtr     (reqPtr),
    .reqOffset  (reqAddr[3:0]),
    .reqTagIn   (reqTagIn),
    .reqReady   (reqReady),
    .strb       (strb),
    .alignErr   (alignErr)
  );

  qtm_datapath #(.DEPTH(DEPTH), .SUB_TAGS(SUB_TAGS)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .idx      (reqAddr[ADDR_W-1:4]),
    .wdata    (reqWdata),
    .rspValid (rspValid),
    .rspData  (rspData),
    .rspTag   (rspTag)
  );
endmodule

// File: tb/test_qword_tag_mem.sv
module test_qword_tag_mem;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 8;
  localparam int NVEC   = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tagsActive = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [2:0] reqSize = 3'd0;
  logic reqPtr = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [127:0] reqWdata = '0;
  logic reqTagIn = 1'b0;
  logic rspValid;
  logic [127:0] rspData;
  logic rspTag;
  logic alignErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] sh [DEPTH][16];

  always #5 clk = ~clk;

  qword_tag_mem i_qword_tag_mem (
    .clk(clk), .rstN(rstN), .tagsActive(tagsActive), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqSize(reqSize), .reqPtr(reqPtr),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqTagIn(reqTagIn),
    .rspValid(rspValid), .rspData(rspData), .rspTag(rspTag), .alignErr(alignErr)
  );

  // Vector: wr, size, ptr, act, quad, offset, seed, tagIn, expValid, expTag, expErr
  function automatic logic [25:0] vec(bit wr, logic [2:0] sz, bit ptr, bit act,
      logic [3:0] q, logic [3:0] off, logic [7:0] seed, bit ti, bit ev, bit et, bit ee);
    return {wr, sz, ptr, act, q, off, seed, ti, ev, et, ee};
  endfunction

  localparam logic [25:0] VEC [NVEC] = '{
    vec(1,4,0,1,1, 0,8'h10,1, 0,0,0),
    vec(0,4,0,1,1, 0,8'h00,0, 1,1,0),
    vec(0,4,1,1,1, 0,8'h00,0, 1,1,0),
    vec(1,0,0,1,1, 5,8'h30,0, 0,0,0),
    vec(0,4,0,1,1, 0,8'h00,0, 1,0,0),
    vec(0,4,1,1,1, 0,8'h00,0, 1,0,0),
    vec(1,4,0,1,2, 0,8'h20,0, 0,0,0),
    vec(0,4,1,1,2, 0,8'h00,0, 1,0,0),
    vec(0,4,1,0,2, 0,8'h00,0, 1,0,0),
    vec(1,4,0,1,3, 0,8'h40,1, 0,0,0),
    vec(1,3,0,0,3, 8,8'h50,0, 0,0,0),
    vec(0,4,0,0,3, 0,8'h00,0, 1,0,0),
    vec(0,4,0,1,3, 0,8'h00,0, 1,1,0),
    vec(1,4,0,0,4, 0,8'h60,1, 0,0,0),
    vec(0,4,0,1,4, 0,8'h00,0, 1,0,0),
    vec(1,4,0,1,5, 0,8'h70,1, 0,0,0),
    vec(1,1,0,1,5,14,8'h80,0, 0,0,0),
    vec(0,4,0,1,5, 0,8'h00,0, 1,0,0),
    vec(1,4,0,1,5, 0,8'h90,1, 0,0,0),
    vec(0,4,1,1,5, 0,8'h00,0, 1,1,0),
    vec(1,4,0,1,6, 0,8'hA0,1, 0,0,0),
    vec(1,4,0,1,6, 4,8'hB0,0, 0,0,1),
    vec(0,4,1,1,6, 0,8'h00,0, 1,1,0),
    vec(0,4,0,1,6, 8,8'h00,0, 0,0,1),
    vec(1,4,0,1,7, 0,8'hC0,1, 0,0,0),
    vec(1,2,0,1,7, 6,8'hD0,0, 0,0,0),
    vec(0,0,0,1,7, 3,8'h00,0, 1,0,0)
  };

  function automatic logic [127:0] pat(logic [7:0] s);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = s + 8'(k * 17);
    return r;
  endfunction

  function automatic logic [127:0] shadowWord(int q);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[8*b +: 8] = sh[q][b];
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One request; outputs sampled at the falling edge after the accepting edge.
  task automatic doOp(bit wr, logic [2:0] sz, bit ptr, bit act, logic [3:0] q,
      logic [3:0] off, logic [7:0] seed, bit ti,
      output logic v, output logic [127:0] d, output logic t, output logic e);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqPtr = ptr; tagsActive = act;
    reqAddr = {q, off}; reqWdata = pat(seed); reqTagIn = ti;
    @(negedge clk);
    v = rspValid; d = rspData; t = rspTag; e = alignErr;
    reqValid = 1'b0;
    if (wr && !(sz >= 3'd4 && off != 4'd0)) begin
      int n;
      int base;
      n = (sz >= 3'd4) ? 16 : (1 << sz);
      base = int'(off) & ~(n - 1);
      for (int b = base; b < base + n; b++) sh[q][b] = pat(seed)[8*b +: 8];
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 128'd0, 128'd1);
      finishRun();
    end
  end

  initial begin
    logic v, t, e;
    logic [127:0] d;
    // R8: outputs during reset
    repeat (3) @(negedge clk);
    check(reqReady == 1'b0, "R8", "ready in reset", 128'(reqReady), 128'd0);
    check(rspValid == 1'b0, "R8", "rspValid in reset", 128'(rspValid), 128'd0);
    check(alignErr == 1'b0, "R8", "alignErr in reset", 128'(alignErr), 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready after reset", 128'(reqReady), 128'd1);
    // R3: idle cycle gives no response
    @(negedge clk);
    check(rspValid == 1'b0, "R3", "idle rspValid", 128'(rspValid), 128'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [25:0] x;
      logic [127:0] expD;
      bit zeroIt;
      x = VEC[i];
      doOp(x[25], x[24:22], x[21], x[20], x[19:16], x[15:12], x[11:4], x[3], v, d, t, e);
      check(e == x[0], "R7", $sformatf("vec %0d alignErr", i), 128'(e), 128'(x[0]));
      check(v == x[2], x[25] ? "R9" : "R3", $sformatf("vec %0d rspValid", i), 128'(v), 128'(x[2]));
      if (x[2]) begin
        check(t == x[1], !x[20] ? "R6" : (x[1] ? "R1" : "R5"),
              $sformatf("vec %0d rspTag", i), 128'(t), 128'(x[1]));
        zeroIt = x[21] && x[20] && (x[24:22] >= 3'd4) && !x[1];
        expD = zeroIt ? 128'd0 : shadowWord(int'(x[19:16]));
        check(d == expD, x[21] ? "R4" : "R2", $sformatf("vec %0d rspData", i), d, expD);
      end
    end

    // R8: reset in mid-run clears tags (quad 3 held tag 1)
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doOp(1'b0, 3'd4, 1'b0, 1'b1, 4'd3, 4'd0, 8'h00, 1'b0, v, d, t, e);
    check(v == 1'b1, "R8", "load after reset valid", 128'(v), 128'd1);
    check(t == 1'b0, "R8", "tag cleared by reset", 128'(t), 128'd0);
    // R4: pointer load of the same quadword after reset reads as null
    doOp(1'b0, 3'd4, 1'b1, 1'b1, 4'd3, 4'd0, 8'h00, 1'b0, v, d, t, e);
    check(d == 128'd0, "R4", "null after reset", d, 128'd0);

    done = 1'b1;
    finishRun();
  end
endmodule